// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block is a serial I/O master. It produces a shift clock and moves a programmable number of bits between one unbuffered 16-bit data register and a pair of serial data pins. The host writes the settings through a configuration strobe:
- the clock half-period count,
- the bit order,
- the transfer length,
- a two-bit mode that selects which pins take part.

A start pulse launches the transfer. A sticky completion flag rises when the last bit has been shifted.

The register is shifted in place and the received data is never re-aligned. A short transfer therefore leaves the received bits at the end of the register opposite to the end that was sent. In the pin-less clock mode the register still shifts. Repeating a transfer takes only a new data write and another start pulse. In the receive-only and clock-only modes the start pulse alone is enough.

The clock idles low. Outgoing data changes after each falling edge of the shift clock. Incoming data is captured on each rising edge. The settings and the data in place before the start edge govern the whole transfer.

Top module: `sio_shifter`

## Requirements
- R1: After reset, and whenever reset is asserted mid-transfer, `sck` is low, `busy`, `irq` and `sdo_en` are 0, and `data_q` is 0.
- R2: After a start is accepted, `sck` stays low for `half+1` system clocks and then high for `half+1` system clocks, for each bit. `busy` stays high for exactly `bits*2*(half+1)` cycles.
- R3: With `cfg_lsb_first`=0, `sdo` presents bit 15 first. Each falling edge shifts the register left, and the incoming bit enters at bit 0.
- R4: With `cfg_lsb_first`=1, `sdo` presents bit 0 first. Each falling edge shifts the register right, and the incoming bit enters at bit 15. Nothing is re-aligned, so a short transfer leaves its received bits in the upper end.
- R5: `cfg_size` values 1 to 15 give that number of bits, and 0 gives 16 bits.
- R6: The `cfg_mode` encoding is fixed:
  - 00 is bidirectional: `sdo` is driven and `sdi` is captured.
  - 01 is output only: `sdo` is driven, `sdi` is ignored and zeros shift in.
  - 10 is input only: `sdo_en` and `sdo` stay 0 and `sdi` is captured.
  - 11 is clock only: `sdo_en` and `sdo` stay 0, and the register still shifts with zeros entering.
- R7: `irq` rises in the cycle `busy` falls at the end of a transfer. It stays set until a cycle with `irq_clr` high clears it.
- R8: While `busy` is high, `data_we`, `cfg_we` and `start` have no effect on the data, the timing or the bit count.
- R9: A start without a preceding data write repeats the transfer on the register's present contents.
- R10: `sdi` is sampled at the system-clock edge where `sck` rises. The sampled bit enters the register at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration fields (only while idle) |
| cfg_half | input | 8 | Shift-clock half-period count; each level lasts this value plus one cycle |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| cfg_size | input | 4 | Bits per transfer, 0 meaning 16 |
| cfg_mode | input | 2 | 00 bidirectional, 01 output only, 10 input only, 11 clock only |
| data_we | input | 1 | Write the data register (only while idle) |
| data_wdata | input | 16 | Data register write value |
| start | input | 1 | Start a transfer (only while idle) |
| irq_clr | input | 1 | Write-one-to-clear of the completion flag |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Shift clock, idle low |
| sdo | output | 1 | Serial data out, 0 when not driven |
| sdo_en | output | 1 | High while `sdo` carries data |
| data_q | output | 16 | Data register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion flag |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- Short least-significant-first transfers, where a design that justifies the received bits would leave them in the low end instead of the high end.
- The size value 0, which a naive counter would read as zero bits or as a hang.
- The clock-only and output-only modes. A design that stopped shifting would leave the register untouched, and one that still captured `sdi` would pull ones in.
- Writes, reconfiguration and a second start during a busy transfer, which a careless design would let alter the data, stretch the clock or restart the bit count.
- A reset in the middle of a transfer, which must park the clock low.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MODE_DUPLEX = 2'b00,
    MODE_TX     = 2'b01,
    MODE_RX     = 2'b10,
    MODE_CLK    = 2'b11
  } sio_mode_e;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          sck,
  output logic          rise_p,
  output logic          fall_p
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          sck_d;
  logic          wrap;

  always_comb begin
    wrap   = run && (cnt_q == half);
    rise_p = wrap && !sck;
    fall_p = wrap && sck;
    cnt_d  = cnt_q;
    sck_d  = sck;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = ~sck;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck   <= sck_d;
    end
  end

  // R2: the shift clock only ever rises while a transfer runs
  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(run));
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl #(
  parameter int DW = 16,
  parameter int SW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fall_p,
  input  logic          irq_clr,
  input  logic [SW-1:0] size,
  output logic          busy,
  output logic          irq
);
  logic [CW-1:0] left_q, left_d;
  logic          busy_d, irq_d;
  logic          last_bit;

  always_comb begin
    last_bit = busy && fall_p && (left_q == CW'(1));
    left_d   = left_q;
    busy_d   = busy;
    irq_d    = irq;
    if (start && !busy) begin
      left_d = (size == '0) ? CW'(DW) : CW'(size);
      busy_d = 1'b1;
    end else if (busy && fall_p) begin
      left_d = left_q - 1'b1;
      if (last_bit) busy_d = 1'b0;
    end
    if (irq_clr)  irq_d = 1'b0;
    if (last_bit) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      left_q <= left_d;
      busy   <= busy_d;
      irq    <= irq_d;
    end
  end

  // R7: completion flag rises together with the end of busy
  a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
  // R8: a transfer only begins from a start pulse
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5: remaining bit count stays within 1..DW during a transfer
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0 && left_q <= CW'(DW)));
endmodule

// File: rtl/sio_shreg.sv
module sio_shreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          sample,
  input  logic          shift,
  input  logic          lsb_first,
  input  logic          cap_en,
  input  logic          sdi,
  output logic [DW-1:0] q,
  output logic          out_bit
);
  logic [DW-1:0] q_d;
  logic          smp_q, smp_d;
  logic          in_bit;

  always_comb begin
    smp_d   = sample ? sdi : smp_q;
    in_bit  = cap_en ? smp_q : 1'b0;
    out_bit = lsb_first ? q[0] : q[DW-1];
    q_d     = q;
    if (load) begin
      q_d = wdata;
    end else if (shift) begin
      if (lsb_first) q_d = {in_bit, q[DW-1:1]};
      else           q_d = {q[DW-2:0], in_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      smp_q <= 1'b0;
    end else begin
      q     <= q_d;
      smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 8,
  localparam int SW = $clog2(DW),
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [HW-1:0] cfg_half,
  input  logic          cfg_lsb_first,
  input  logic [SW-1:0] cfg_size,
  input  logic [1:0]    cfg_mode,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic          start,
  input  logic          irq_clr,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic          sdo_en,
  output logic [DW-1:0] data_q,
  output logic          busy,
  output logic          irq
);
  logic [HW-1:0] half_q;
  logic          lsb_q;
  logic [SW-1:0] size_q;
  sio_mode_e     mode_q;
  logic          cfg_load;
  logic          rise_p, fall_p;
  logic          cap_en, drv_en, out_bit;

  assign cfg_load = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      lsb_q  <= 1'b0;
      size_q <= '0;
      mode_q <= MODE_DUPLEX;
    end else if (cfg_load) begin
      half_q <= cfg_half;
      lsb_q  <= cfg_lsb_first;
      size_q <= cfg_size;
      mode_q <= sio_mode_e'(cfg_mode);
    end
  end

  always_comb begin
    cap_en = (mode_q == MODE_DUPLEX) || (mode_q == MODE_RX);
    drv_en = (mode_q == MODE_DUPLEX) || (mode_q == MODE_TX);
    sdo_en = busy && drv_en;
    sdo    = sdo_en && out_bit;
  end

  sio_clkgen #(.HW(HW)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q),
    .sck(sck), .rise_p(rise_p), .fall_p(fall_p)
  );

  sio_ctrl #(.DW(DW), .SW(SW), .CW(CW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fall_p(fall_p),
    .irq_clr(irq_clr), .size(size_q), .busy(busy), .irq(irq)
  );

  sio_shreg #(.DW(DW)) shreg_i (
    .clk(clk), .rst_n(rst_n), .load(data_we && !busy), .wdata(data_wdata),
    .sample(rise_p), .shift(busy && fall_p), .lsb_first(lsb_q),
    .cap_en(cap_en), .sdi(sdi), .q(data_q), .out_bit(out_bit)
  );

  // R1: clock parked low whenever no transfer runs
  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R6: data pin silent in input-only and clock-only modes
  a_r6_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RX || mode_q == MODE_CLK) |-> (!sdo_en && !sdo));
  // R8: register only moves on a shift edge while busy
  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_p) |=> $stable(data_q));
  // R2: timing settings cannot change mid-transfer
  a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(half_q));
endmodule

// File: tb/sio_shifter_tb_top.sv
module sio_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_lsb_first, data_we, start, irq_clr, sdi;
  logic [7:0]  cfg_half;
  logic [3:0]  cfg_size;
  logic [1:0]  cfg_mode;
  logic [15:0] data_wdata;
  logic        sck, sdo, sdo_en, busy, irq;
  logic [15:0] data_q;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  sio_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_half(cfg_half),
    .cfg_lsb_first(cfg_lsb_first), .cfg_size(cfg_size), .cfg_mode(cfg_mode),
    .data_we(data_we), .data_wdata(data_wdata), .start(start),
    .irq_clr(irq_clr), .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_en(sdo_en),
    .data_q(data_q), .busy(busy), .irq(irq)
  );

  // {half[46:39], lsb[38], size[37:34], mode[33:32], data[31:16], sdi stream[15:0]}
  localparam logic [46:0] VEC [8] = '{
    {8'd1, 1'b0, 4'd8,  2'b00, 16'hA5C3, 16'h00B6},
    {8'd0, 1'b1, 4'd8,  2'b00, 16'h1234, 16'h005A},
    {8'd2, 1'b0, 4'd0,  2'b00, 16'hF00F, 16'h9C31},
    {8'd0, 1'b1, 4'd1,  2'b01, 16'h0001, 16'hFFFF},
    {8'd1, 1'b0, 4'd5,  2'b10, 16'h8421, 16'h0015},
    {8'd0, 1'b1, 4'd12, 2'b11, 16'hBEEF, 16'hFFFF},
    {8'd3, 1'b0, 4'd15, 2'b01, 16'h7E81, 16'h5555},
    {8'd0, 1'b1, 4'd0,  2'b10, 16'h0000, 16'hACE1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; data_we = 0; start = 0; irq_clr = 0;
  endtask

  task automatic run_case(input logic [7:0] h, input bit lsb, input logic [3:0] sz,
                          input logic [1:0] md, input logic [15:0] d,
                          input logic [15:0] ip, input bit load, input bit disturb,
                          input string dtag);
    logic [15:0] r;
    logic        exp_out [16];
    int          n, k, cycles;
    bit          inb, drv, prev;
    n = (sz == 0) ? 16 : int'(sz);
    drv = (md == 2'b00) || (md == 2'b01);
    r = d;
    for (int i = 0; i < n; i++) begin
      exp_out[i] = lsb ? r[0] : r[15];
      inb = ((md == 2'b00) || (md == 2'b10)) ? ip[i] : 1'b0;
      r = lsb ? {inb, r[15:1]} : {r[14:0], inb};
    end
    @(negedge clk);
    cfg_we = 1; cfg_half = h; cfg_lsb_first = lsb; cfg_size = sz; cfg_mode = md;
    data_we = load; data_wdata = d; sdi = ip[0];
    @(negedge clk);
    idle_inputs(); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    cycles = 0; k = 0; prev = 0;
    while (busy === 1'b1 && cycles < 5000) begin
      cycles++;
      idle_inputs();
      if (disturb && cycles == 2) begin
        data_we = 1; data_wdata = ~d; start = 1;
        cfg_we = 1; cfg_half = h + 8'd3; cfg_size = 4'd2;
      end
      if (sck && !prev) begin
        if (k < 16) begin
          chk(sdo === (drv ? exp_out[k] : 1'b0), lsb ? "R4 sdo bit" : "R3 sdo bit",
              int'(sdo), int'(drv ? exp_out[k] : 1'b0));
        end
        chk(sdo_en === drv, "R6 sdo_en", int'(sdo_en), int'(drv));
        k++;
      end
      if (!sck && prev) sdi = (k < 16) ? ip[k] : 1'b0;
      prev = sck;
      @(negedge clk);
    end
    idle_inputs();
    chk(cycles == n * 2 * (int'(h) + 1), "R2 busy length", cycles, n * 2 * (int'(h) + 1));
    chk(k == n, "R5 bit count", k, n);
    chk(data_q === r, dtag, int'(data_q), int'(r));
    chk(irq === 1'b1 && sck === 1'b0, "R7 irq at end", int'({irq, sck}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs(); cfg_half = 0; cfg_lsb_first = 0; cfg_size = 0;
    cfg_mode = 0; data_wdata = 0; sdi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sck === 0 && busy === 0 && irq === 0 && sdo_en === 0 && data_q === 16'h0,
        "R1 reset state", int'({sck, busy, irq, sdo_en}), 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [46:0] e;
      e = VEC[v];
      run_case(e[46:39], e[38], e[37:34], e[33:32], e[31:16], e[15:0], 1'b1, 1'b0,
               (e[33:32] == 2'b00 || e[33:32] == 2'b10) ? "R10 captured data" : "R6 shifted data");
      // R7 flag held, then cleared
      repeat (4) @(negedge clk);
      chk(irq === 1'b1, "R7 irq held", int'(irq), 1);
      irq_clr = 1;
      @(negedge clk);
      irq_clr = 0;
      chk(irq === 1'b0, "R7 irq cleared", int'(irq), 0);
    end

    // R4 no justification: 8-bit lsb-first duplex with sdi all ones
    run_case(8'd0, 1'b1, 4'd8, 2'b00, 16'h00C3, 16'hFFFF, 1'b1, 1'b0, "R4 upper byte fill");
    chk(data_q === 16'hFF00, "R4 received in high byte", int'(data_q), 16'hFF00);

    // R8 writes, reconfiguration and start while busy ignored
    run_case(8'd1, 1'b0, 4'd6, 2'b00, 16'h3C5A, 16'h0029, 1'b1, 1'b1, "R8 data untouched");

    // R9 repeat with start alone, register contents reused
    run_case(8'd0, 1'b0, 4'd4, 2'b11, 16'h3C5A, 16'h0000, 1'b1, 1'b0, "R9 first run");
    run_case(8'd0, 1'b0, 4'd4, 2'b11, data_q, 16'h0000, 1'b0, 1'b0, "R9 repeat run");
    chk(data_q === 16'h5A00, "R9 two runs", int'(data_q), 16'h5A00);

    // R1 reset mid-transfer
    @(negedge clk);
    cfg_we = 1; cfg_half = 8'd2; cfg_size = 4'd8; cfg_mode = 2'b00;
    @(negedge clk);
    idle_inputs(); start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b1 && sck === 1'b1, "R2 mid-transfer high phase", int'({busy, sck}), 3);
    rst_n = 0;
    @(negedge clk);
    chk(sck === 0 && busy === 0 && irq === 0 && sdo_en === 0 && data_q === 16'h0,
        "R1 reset mid-transfer", int'({sck, busy, irq, sdo_en}), 0);
    rst_n = 1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule